// File: doc/BRIEF.md
# Folded Static Memory Array with Phased Access

This block is a cycle-accurate behavioural model of a 2048-word by 16-bit static memory. The words are laid out as 256 physical rows of 128 cells each, so the array stays close to square. An 11-bit request address is split into two fields. The upper 8 bits form the row field, which drives a predecoded wordline decoder. The lower 3 bits form the column field, which steers sixteen 8-to-1 column selectors. Each selector serves one bit of the data word.

Each request walks through a fixed chain of one-clock phases:

- **Bitline preparation.** On a read, both bitline rails of every column are precharged high. On a write, the new data is driven onto the selected columns as a true/complement pair.
- **Wordline.** Exactly one row is enabled.
- **Sense or commit.** On a read, the sensed row passes through the column selectors into the read data register. On a write, the bitlines are released.
- **Completion.** One cycle with a completion pulse.

A new request is accepted only when the block is idle.

Top module: `sram_fold_array`

## Requirements
- R1: While reset is held and directly after it, `rsp_done` is 0 and `rsp_rdata` is 0.
- R2: A read returns the data last written to the same logical address. The row field is `req_addr[10:3]` and the column field is `req_addr[2:0]`.
- R3: A write changes only the 16 cells chosen by its column field within its row. The other seven words sharing that row keep their values.
- R4: If a request is accepted at clock edge N, `rsp_done` is high exactly from edge N+3 to edge N+4 and low in the cycle that follows.
- R5: A request presented while an access is in progress is ignored. It neither writes the array nor changes the access under way.
- R6: `rsp_rdata` changes only when a read completes. It holds through write accesses and idle cycles.
- R7: At most one wordline is active at any time. Exactly one is active during the wordline phase, and none is active in any other phase.
- R8: On a read, both rails of every bitline are high when the wordline is raised.
- R9: On a write, exactly the 16 selected columns carry complementary rail values when the wordline is raised. Column `i*8 + col` holds data bit `i`. All other columns keep both rails high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Logical word address |
| req_wdata | input | 16 | Data to write |
| rsp_rdata | output | 16 | Data from the most recent completed read |
| rsp_done | output | 1 | One-cycle completion pulse |

## Verification
The in-RTL properties check the following on every cycle:

- the single-wordline and phase-gating rule;
- the precharged state of both rails before a read row is enabled;
- the complementary drive of exactly the addressed columns before a write row is enabled;
- the one-cycle completion pulse;
- the stability of the latched request and of the read data register.

Only the bench scenarios can show that data survives a round trip to the correct logical address. Those scenarios also show that neighbouring words in a shared row are left intact, and that a request arriving mid-access has no effect on stored contents.

// File: rtl/sram_fold_pkg.sv
package sram_fold_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PREP,
    PH_WORDLINE,
    PH_SENSE,
    PH_COMMIT,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/row_predecoder.sv
module row_predecoder #(
  parameter int SEL_W = 8
) (
  input  logic                  en,
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] wordline
);
  localparam int GROUPS = SEL_W / 2;
  localparam int ROWS   = 1 << SEL_W;

  // one 1-of-4 hot group per address pair
  logic [3:0] pre [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_pre
    assign pre[g] = 4'b0001 << sel[2*g +: 2];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_wl
    localparam logic [SEL_W-1:0] ROW_IDX = SEL_W'(r);
    logic [GROUPS-1:0] hits;
    for (genvar g = 0; g < GROUPS; g++) begin : g_hit
      assign hits[g] = pre[g][ROW_IDX[2*g +: 2]];
    end
    assign wordline[r] = en & (&hits);
  end
endmodule

// File: rtl/col_mux.sv
module col_mux #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic [WORD_W*(1<<SEL_W)-1:0] row_in,
  input  logic [SEL_W-1:0]             sel,
  output logic [WORD_W-1:0]            word_out
);
  localparam int WAYS = 1 << SEL_W;

  // selector i owns columns i*WAYS .. i*WAYS+WAYS-1
  for (genvar i = 0; i < WORD_W; i++) begin : g_sel
    logic [WAYS-1:0] group;
    assign group       = row_in[i*WAYS +: WAYS];
    assign word_out[i] = group[sel];
  end
endmodule

// File: rtl/sram_fold_array.sv
module sram_fold_array
  import sram_fold_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 11,
  parameter int COL_SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_done
);
  localparam int WAYS      = 1 << COL_SEL_W;
  localparam int ROW_SEL_W = ADDR_W - COL_SEL_W;
  localparam int ROWS      = 1 << ROW_SEL_W;
  localparam int ROW_W     = WORD_W * WAYS;

  function automatic logic [ROW_W-1:0] col_mask(input logic [COL_SEL_W-1:0] c);
    logic [ROW_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) m[i*WAYS + int'(c)] = 1'b1;
    return m;
  endfunction

  function automatic logic [ROW_W-1:0] spread(input logic [WORD_W-1:0] w,
                                              input logic [COL_SEL_W-1:0] c);
    logic [ROW_W-1:0] s;
    s = '0;
    for (int i = 0; i < WORD_W; i++) s[i*WAYS + int'(c)] = w[i];
    return s;
  endfunction

  phase_t                 phase;
  logic [ROW_SEL_W-1:0]   lat_row;
  logic [COL_SEL_W-1:0]   lat_col;
  logic                   lat_we;
  logic [ROW_W-1:0]       bl_t, bl_c;
  logic [WORD_W-1:0]      rdata_q;

  // named internal events
  logic                   wl_phase;
  logic [ROWS-1:0]        wordline;
  logic [ROW_W-1:0]       drive_mask;
  logic [ROW_W-1:0]       row_on_bl;
  logic [WORD_W-1:0]      mux_out;
  logic [ROW_W-1:0]       row_q [ROWS];

  assign wl_phase   = (phase == PH_WORDLINE);
  assign drive_mask = bl_t ^ bl_c;

  row_predecoder #(.SEL_W(ROW_SEL_W)) u_rowdec (
    .en      (wl_phase),
    .sel     (lat_row),
    .wordline(wordline)
  );

  // cell rows: a row takes the driven columns only while its wordline is up
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [ROW_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (wordline[r] && lat_we)
        cell_q <= (cell_q & ~drive_mask) | (bl_t & drive_mask);
    end
    assign row_q[r] = cell_q;
  end

  always_comb begin
    row_on_bl = '0;
    for (int r = 0; r < ROWS; r++)
      if (wordline[r]) row_on_bl = row_on_bl | row_q[r];
  end

  col_mux #(.WORD_W(WORD_W), .SEL_W(COL_SEL_W)) u_colmux (
    .row_in  (bl_t),
    .sel     (lat_col),
    .word_out(mux_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      lat_row <= '0;
      lat_col <= '0;
      lat_we  <= 1'b0;
      bl_t    <= '1;
      bl_c    <= '1;
      rdata_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          lat_row <= req_addr[ADDR_W-1:COL_SEL_W];
          lat_col <= req_addr[COL_SEL_W-1:0];
          lat_we  <= req_write;
          if (req_write) begin
            bl_t <= ~col_mask(req_addr[COL_SEL_W-1:0])
                    | spread(req_wdata, req_addr[COL_SEL_W-1:0]);
            bl_c <= ~col_mask(req_addr[COL_SEL_W-1:0])
                    | spread(~req_wdata, req_addr[COL_SEL_W-1:0]);
          end else begin
            bl_t <= '1;
            bl_c <= '1;
          end
          phase <= PH_PREP;
        end
        PH_PREP: phase <= PH_WORDLINE;
        PH_WORDLINE: begin
          if (!lat_we) begin
            bl_t  <= row_on_bl;
            bl_c  <= ~row_on_bl;
            phase <= PH_SENSE;
          end else begin
            phase <= PH_COMMIT;
          end
        end
        PH_SENSE: begin
          rdata_q <= mux_out;
          phase   <= PH_DONE;
        end
        PH_COMMIT: begin
          bl_t  <= '1;
          bl_c  <= '1;
          phase <= PH_DONE;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign rsp_rdata = rdata_q;
  assign rsp_done  = (phase == PH_DONE);

  // R7: one wordline in the wordline phase, none otherwise
  p_single_wordline_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wordline) == (wl_phase ? 1 : 0));
  p_wordline_onehot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wordline));
  // R8: rails precharged when a read row opens
  p_read_precharged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_phase && !lat_we) |-> ((&bl_t) && (&bl_c)));
  // R9: only addressed columns driven complementary when a write row opens
  p_write_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_phase && lat_we) |-> (drive_mask == col_mask(lat_col)));
  // R4: completion lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R5: latched request held while busy
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ($stable(lat_row) && $stable(lat_col) && $stable(lat_we)));
  // R6: read data moves only on read completion
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_SENSE) |=> $stable(rsp_rdata));
endmodule

// File: tb/tb_sram_fold_array.sv
module tb_sram_fold_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_done;

  int checks = 0;
  int fails  = 0;

  logic [15:0] ref_mem [2048];

  typedef struct packed {
    logic        we;
    logic [10:0] addr;
    logic [15:0] data;  // write data, or expected read data
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 11'h010, 16'hA5A5},
    '{1'b1, 11'h011, 16'h5A5A},
    '{1'b1, 11'h017, 16'hFFFF},
    '{1'b0, 11'h010, 16'hA5A5},
    '{1'b0, 11'h011, 16'h5A5A},
    '{1'b0, 11'h017, 16'hFFFF},
    '{1'b1, 11'h011, 16'h0000},
    '{1'b0, 11'h010, 16'hA5A5},
    '{1'b0, 11'h011, 16'h0000},
    '{1'b1, 11'h7FF, 16'h1234},
    '{1'b1, 11'h000, 16'hBEEF},
    '{1'b0, 11'h7FF, 16'h1234},
    '{1'b0, 11'h000, 16'hBEEF},
    '{1'b0, 11'h017, 16'hFFFF}
  };

  sram_fold_array dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; returns latency in negedges after the accepting edge
  task automatic access(input logic we, input logic [10:0] a,
                        input logic [15:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    if (we) ref_mem[a] = d;
  endtask

  task automatic access_checked(input logic we, input logic [10:0] a,
                                input logic [15:0] d);
    int lat;
    access(we, a, d, lat);
    check(lat == 4, "R4 latency", 16'(lat), 16'd4);
    if (!we) check(rsp_rdata == ref_mem[a], "R2/R3 read data", rsp_rdata, ref_mem[a]);
    @(negedge clk);
    check(!rsp_done, "R4 single pulse", 16'(rsp_done), 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    int lat;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(rsp_done == 1'b0, "R1 done in reset", 16'(rsp_done), 16'd0);
    check(rsp_rdata == 16'h0, "R1 rdata in reset", rsp_rdata, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_done == 1'b0 && rsp_rdata == 16'h0, "R1 after reset", rsp_rdata, 16'h0);

    // vector table: R2 round trip, R3 shared-row neighbours, R4 timing
    for (int v = 0; v < NVEC; v++) begin
      access(VECS[v].we, VECS[v].addr, VECS[v].data, lat);
      check(lat == 4, "R4 latency (table)", 16'(lat), 16'd4);
      if (!VECS[v].we)
        check(rsp_rdata == VECS[v].data, "R2/R3 table read", rsp_rdata, VECS[v].data);
    end

    // random mixed traffic on a few rows (R2, R3); the in-RTL
    // properties watch R7, R8 and R9 throughout this traffic
    for (int c = 0; c < 8; c++) begin
      access_checked(1'b1, {8'd5, 3'(c)}, 16'(c * 16'h1111));
      access_checked(1'b1, {8'd6, 3'(c)}, 16'(~(c * 16'h0101)));
      access_checked(1'b1, {8'd200, 3'(c)}, 16'(c + 16'h4000));
    end
    for (int n = 0; n < 300; n++) begin
      logic [7:0]  row;
      logic [10:0] a;
      int sel;
      sel = int'($urandom_range(0, 2));
      row = (sel == 0) ? 8'd5 : (sel == 1) ? 8'd6 : 8'd200;
      a = {row, 3'($urandom_range(0, 7))};
      access_checked(1'($urandom_range(0, 1)), a, 16'($urandom));
    end

    // R5: request held high during a busy access is ignored
    access_checked(1'b1, 11'h031, 16'h2222);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h030; req_wdata = 16'h1111;
    @(negedge clk);
    req_addr = 11'h031; req_wdata = 16'hDEAD;
    while (!rsp_done) @(negedge clk);
    req_valid = 1'b0;
    ref_mem[11'h030] = 16'h1111;
    @(negedge clk);
    access(1'b0, 11'h031, 16'h0, lat);
    check(rsp_rdata == 16'h2222, "R5 busy request ignored", rsp_rdata, 16'h2222);
    access(1'b0, 11'h030, 16'h0, lat);
    check(rsp_rdata == 16'h1111, "R5 accepted request intact", rsp_rdata, 16'h1111);

    // R6: read data held through a write and idle cycles
    access(1'b0, 11'h7FF, 16'h0, lat);
    held = rsp_rdata;
    check(held == 16'h1234, "R6 setup read", held, 16'h1234);
    access(1'b1, 11'h7FE, 16'h9876, lat);
    check(rsp_rdata == held, "R6 hold across write", rsp_rdata, held);
    repeat (5) @(negedge clk);
    check(rsp_rdata == held, "R6 hold while idle", rsp_rdata, held);
    access(1'b0, 11'h7FE, 16'h0, lat);
    check(rsp_rdata == 16'h9876, "R6 update on read / R3 neighbour", rsp_rdata, 16'h9876);
    access(1'b0, 11'h7FF, 16'h0, lat);
    check(rsp_rdata == 16'h1234, "R3 neighbour kept", rsp_rdata, 16'h1234);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule